// File: doc/BRIEF.md
# Radio Wake and Analog Control Register Slice

This block is a small set of control and status registers that sits behind a plain synchronous register bus. The bus has an address, write data, a write strobe, a read strobe and read data. The slice holds three registers. The first is a wake interrupt enable. The second is a wake status flag that software can only read, and reading it clears it. The third is an analog control register. From these registers the block drives an interrupt line, the control pin of an external power amplifier with a programmable polarity, an unlock signal for two write-protected registers elsewhere, an enable for the manufacturing-ID readout, and a one-cycle soft-reset pulse.

A wake event is the cycle in which the condition "power-down input low and device ready high" becomes true after being false. The event sets the wake status whether or not the interrupt is enabled. The interrupt line reports the status only while the enable is set.

The analog register enforces a rule that software must not flip the amplifier enable and its polarity in the same write. Writing a 1 to its bit 0 starts a self-clearing reset of the whole slice.

Top module: `radio_wake_ctl`

## Requirements
- R1: After reset, wake enable reads 0x00 at 0x1C, wake status reads 0x00 at 0x1D and analog control reads 0x01 at 0x20. After reset, irq, pa_ctl, pa_ctl_oe, prot_wr_unlock, mfg_id_en and soft_rst are all 0.
- R2: A write to 0x1C stores wdata bit 0 as the wake interrupt enable. Bits 7:1 of 0x1C read as 0.
- R3: Each rising edge of the condition (pwr_down==0 and dev_ready==1) sets the wake status bit 0 at the next clock edge, whatever the enable is. irq equals enable AND status.
- R4: A read strobe at 0x1D returns the status in the same cycle and clears it at that clock edge. A wake event in that same cycle wins, and the status stays 1.
- R5: Writes to 0x1D have no effect on the status.
- R6: In 0x20, bit 6 drives prot_wr_unlock and bit 5 drives mfg_id_en. Bits 7, 4 and 3 read as 0 whatever is written.
- R7: Bit 2 of 0x20 (amplifier enable) drives pa_ctl_oe. While it is 1, pa_ctl equals pa_req when bit 1 (invert) is 0, and NOT pa_req when bit 1 is 1. While it is 0, pa_ctl is 0.
- R8: A write to 0x20 with bit 0 = 0 that would change both bit 2 and bit 1 updates bit 2 only and keeps bit 1.
- R9: A write to 0x20 with bit 0 = 1 ignores the other data bits. In the next cycle soft_rst is 1 for exactly one cycle, and every register is back to its R1 value. A wake event in the same cycle as this write is lost.
- R10: When bus_re is 0, or the address is not 0x1C, 0x1D or 0x20, bus_rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| pwr_down | input | 1 | Power-down request, high = powered down |
| dev_ready | input | 1 | Device ready for bus traffic |
| pa_req | input | 1 | Amplifier-on request from the transmitter |
| irq | output | 1 | Wake interrupt |
| pa_ctl | output | 1 | External amplifier control level |
| pa_ctl_oe | output | 1 | Drive enable for the amplifier pin |
| prot_wr_unlock | output | 1 | Write unlock for the two protected registers |
| mfg_id_en | output | 1 | Manufacturing-ID read/power enable |
| soft_rst | output | 1 | One-cycle soft reset pulse |

## Verification
Read data, pa_ctl and pa_ctl_oe are combinational from the stored state and the inputs, so they are due in the same cycle. The bench samples them 1 ns after it drives the inputs, before the next edge. Register updates, status set or clear, irq, the unlock and ID enables, and soft_rst are due one edge after the causing cycle. The bench advances its reference model at that same edge and compares 1 ns after it. After rst_n rises, the internal reset takes two more edges to release, and the bench waits for them before it starts.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  localparam int DW = 8;
  localparam logic [7:0] ADR_WAKE_EN   = 8'h1C;
  localparam logic [7:0] ADR_WAKE_STAT = 8'h1D;
  localparam logic [7:0] ADR_ANA       = 8'h20;

  // writable fields of the analog control register
  typedef struct packed {
    logic unlock;   // bit 6
    logic mfg_en;   // bit 5
    logic pa_oe;    // bit 2
    logic pa_inv;   // bit 1
    logic rst_bit;  // bit 0
  } ana_t;

  localparam ana_t ANA_DEFAULT = '{unlock: 1'b0, mfg_en: 1'b0, pa_oe: 1'b0,
                                   pa_inv: 1'b0, rst_bit: 1'b1};

  function automatic logic [DW-1:0] ana_pack(ana_t a);
    return {1'b0, a.unlock, a.mfg_en, 2'b00, a.pa_oe, a.pa_inv, a.rst_bit};
  endfunction
endpackage

// File: rtl/rwc_wake_unit.sv
module rwc_wake_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic dev_ready,
  input  logic en_we,
  input  logic en_wbit,
  input  logic stat_rd,
  input  logic soft_clr,
  output logic en_q,
  output logic stat_q,
  output logic irq
);
  logic cond, cond_q, evt;
  logic en_d, stat_d;

  assign cond = ~pwr_down & dev_ready;
  assign evt  = cond & ~cond_q;

  always_comb begin
    en_d   = en_q;
    stat_d = stat_q;
    if (soft_clr) begin
      en_d   = 1'b0;
      stat_d = 1'b0;
    end else begin
      if (en_we) en_d = en_wbit;
      if (evt)          stat_d = 1'b1;
      else if (stat_rd) stat_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      stat_q <= 1'b0;
      cond_q <= 1'b1;
    end else begin
      en_q   <= en_d;
      stat_q <= stat_d;
      cond_q <= cond;
    end
  end

  assign irq = en_q & stat_q;
endmodule

// File: rtl/rwc_ana_unit.sv
module rwc_ana_unit
  import rwc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ana_we,
  input  logic [DW-1:0] wdata,
  output ana_t          ana_q,
  output logic          soft_rst,
  output logic          soft_req
);
  ana_t ana_d;
  logic both_flip;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[7], wdata[4:3]};
  assign soft_req  = ana_we & wdata[0];
  assign both_flip = (wdata[2] != ana_q.pa_oe) && (wdata[1] != ana_q.pa_inv);

  always_comb begin
    ana_d = ana_q;
    if (soft_req) begin
      ana_d = ANA_DEFAULT;
    end else if (ana_we) begin
      ana_d.unlock  = wdata[6];
      ana_d.mfg_en  = wdata[5];
      ana_d.pa_oe   = wdata[2];
      ana_d.pa_inv  = both_flip ? ana_q.pa_inv : wdata[1];
      ana_d.rst_bit = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ana_q    <= ANA_DEFAULT;
      soft_rst <= 1'b0;
    end else begin
      ana_q    <= ana_d;
      soft_rst <= soft_req;
    end
  end
endmodule

// File: rtl/rwc_pa_driver.sv
module rwc_pa_driver (
  input  logic oe,
  input  logic inv,
  input  logic req,
  output logic pin,
  output logic pin_oe
);
  assign pin_oe = oe;
  assign pin    = oe & (req ^ inv);
endmodule

// File: rtl/radio_wake_ctl.sv
module radio_wake_ctl
  import rwc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DW-1:0]     bus_rdata,
  input  logic              pwr_down,
  input  logic              dev_ready,
  input  logic              pa_req,
  output logic              irq,
  output logic              pa_ctl,
  output logic              pa_ctl_oe,
  output logic              prot_wr_unlock,
  output logic              mfg_id_en,
  output logic              soft_rst
);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADR_WAKE_EN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_WAKE_STAT);
  localparam logic [ADDR_W-1:0] A_ANA  = ADDR_W'(ADR_ANA);

  logic [1:0] rst_sync;
  logic       rst_sync_n;
  logic       en_q, stat_q, soft_req;
  ana_t       ana_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  rwc_wake_unit u_wake (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pwr_down (pwr_down),
    .dev_ready(dev_ready),
    .en_we    (bus_we && bus_addr == A_EN),
    .en_wbit  (bus_wdata[0]),
    .stat_rd  (bus_re && bus_addr == A_STAT),
    .soft_clr (soft_req),
    .en_q     (en_q),
    .stat_q   (stat_q),
    .irq      (irq)
  );

  rwc_ana_unit u_ana (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ana_we  (bus_we && bus_addr == A_ANA),
    .wdata   (bus_wdata),
    .ana_q   (ana_q),
    .soft_rst(soft_rst),
    .soft_req(soft_req)
  );

  rwc_pa_driver u_pa (
    .oe    (ana_q.pa_oe),
    .inv   (ana_q.pa_inv),
    .req   (pa_req),
    .pin   (pa_ctl),
    .pin_oe(pa_ctl_oe)
  );

  assign prot_wr_unlock = ana_q.unlock;
  assign mfg_id_en      = ana_q.mfg_en;

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      unique case (bus_addr)
        A_EN:    bus_rdata = {{(DW-1){1'b0}}, en_q};
        A_STAT:  bus_rdata = {{(DW-1){1'b0}}, stat_q};
        A_ANA:   bus_rdata = ana_pack(ana_q);
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rwc_checker.sv
module rwc_checker
  import rwc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_ok,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic              pwr_down,
  input logic              dev_ready,
  input logic              irq,
  input logic              pa_ctl,
  input logic              pa_ctl_oe,
  input logic              prot_wr_unlock,
  input logic              mfg_id_en,
  input logic              soft_rst,
  input logic              pa_oe,
  input logic              pa_inv
);
  logic wr_ana, wr_rst;
  assign wr_ana = bus_we && bus_addr == ADDR_W'(ADR_ANA);
  assign wr_rst = wr_ana && bus_wdata[0];

  a_r9_pulse_one: assert property (@(posedge clk) disable iff (!rst_ok)
    (soft_rst && !wr_rst) |=> !soft_rst);

  a_r9_defaults: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_rst |=> (soft_rst && !irq && !pa_ctl_oe && !prot_wr_unlock && !mfg_id_en));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_re && bus_addr == ADDR_W'(ADR_WAKE_STAT) && (pwr_down || !dev_ready)) |=> !irq);

  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_ok)
    !pa_ctl_oe |-> !pa_ctl);

  a_r8_inv_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_ana && !bus_wdata[0] && bus_wdata[2] != pa_oe && bus_wdata[1] != pa_inv)
      |=> ($stable(pa_inv) && pa_oe == $past(bus_wdata[2])));

  a_r6_unlock_src: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(prot_wr_unlock) |-> $past(wr_ana));
endmodule

bind radio_wake_ctl rwc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_ok        (rst_sync_n),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_we        (bus_we),
  .bus_re        (bus_re),
  .pwr_down      (pwr_down),
  .dev_ready     (dev_ready),
  .irq           (irq),
  .pa_ctl        (pa_ctl),
  .pa_ctl_oe     (pa_ctl_oe),
  .prot_wr_unlock(prot_wr_unlock),
  .mfg_id_en     (mfg_id_en),
  .soft_rst      (soft_rst),
  .pa_oe         (ana_q.pa_oe),
  .pa_inv        (ana_q.pa_inv)
);

// File: tb/radio_wake_ctl_tb.sv
module radio_wake_ctl_tb;
  localparam logic [7:0] A_EN = 8'h1C, A_ST = 8'h1D, A_AN = 8'h20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic       bus_we = 1'b0, bus_re = 1'b0;
  logic       pwr_down = 1'b1, dev_ready = 1'b0, pa_req = 1'b0;
  logic       irq, pa_ctl, pa_ctl_oe, prot_wr_unlock, mfg_id_en, soft_rst;

  int checks = 0, errors = 0;
  logic       m_en, m_stat, m_prev, m_soft;
  logic [7:0] m_ana;

  always #4 clk = ~clk;

  radio_wake_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pwr_down(pwr_down), .dev_ready(dev_ready), .pa_req(pa_req),
    .irq(irq), .pa_ctl(pa_ctl), .pa_ctl_oe(pa_ctl_oe),
    .prot_wr_unlock(prot_wr_unlock), .mfg_id_en(mfg_id_en), .soft_rst(soft_rst)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ana_apply(logic [7:0] cur, logic [7:0] w);
    logic [7:0] n;
    n = w & 8'h66;
    if (w[2] != cur[2] && w[1] != cur[1]) n[1] = cur[1];
    return n;
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a, logic re);
    if (!re) return 8'h00;
    case (a)
      A_EN:    return {7'b0, m_en};
      A_ST:    return {7'b0, m_stat};
      A_AN:    return m_ana;
      default: return 8'h00;
    endcase
  endfunction

  // reference model advance for one clock edge, then wait for that edge
  task automatic tick();
    logic cond, evt;
    cond = !pwr_down && dev_ready;
    evt  = cond && !m_prev;
    if (bus_we && bus_addr == A_AN && bus_wdata[0]) begin
      m_en = 1'b0; m_stat = 1'b0; m_ana = 8'h01; m_soft = 1'b1;
    end else begin
      m_soft = 1'b0;
      if (bus_we && bus_addr == A_EN) m_en = bus_wdata[0];
      if (bus_we && bus_addr == A_AN) m_ana = ana_apply(m_ana, bus_wdata);
      if (evt) m_stat = 1'b1;
      else if (bus_re && bus_addr == A_ST) m_stat = 1'b0;
    end
    m_prev = cond;
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(string req, logic [7:0] a);
    bus_addr = a; bus_re = 1'b1; #1;
    chk(req, bus_rdata, exp_rd(a, 1'b1));
    tick();
    bus_re = 1'b0;
  endtask

  task automatic chk_outs(string req);
    chk({req, " irq"},    {7'b0, irq},            {7'b0, m_en & m_stat});
    chk({req, " soft"},   {7'b0, soft_rst},       {7'b0, m_soft});
    chk({req, " unlock"}, {7'b0, prot_wr_unlock}, {7'b0, m_ana[6]});
    chk({req, " mfg"},    {7'b0, mfg_id_en},      {7'b0, m_ana[5]});
    chk({req, " pa_oe"},  {7'b0, pa_ctl_oe},      {7'b0, m_ana[2]});
    chk({req, " pa"},     {7'b0, pa_ctl},         {7'b0, m_ana[2] & (pa_req ^ m_ana[1])});
  endtask

  // produce a wake event edge
  task automatic wake_pulse();
    pwr_down = 1'b1; dev_ready = 1'b1; tick();
    pwr_down = 1'b0; tick();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    m_en = 0; m_stat = 0; m_ana = 8'h01; m_soft = 0; m_prev = 0;

    // R1 reset state
    rd("R1 wake_en", A_EN);
    rd("R1 wake_stat", A_ST);
    rd("R1 ana", A_AN);
    chk_outs("R1");

    // R2 enable bit and reserved bits
    wr(A_EN, 8'hFE); rd("R2 en reserved", A_EN);
    wr(A_EN, 8'hFF); rd("R2 en set", A_EN);
    wr(A_EN, 8'h00);

    // R3 event with enable off: status set, no irq
    wake_pulse(); chk_outs("R3 en off");
    chk("R3 stat", {7'b0, m_stat}, 8'h01);
    wr(A_EN, 8'h01); chk_outs("R3 en on");
    chk("R3 irq", {7'b0, irq}, 8'h01);

    // R5 write to status ignored
    wr(A_ST, 8'h00); rd("R5 stat kept", A_ST);

    // R4 read clears (the read above cleared it), then read with same-cycle event
    chk("R4 cleared", {7'b0, irq}, 8'h00);
    pwr_down = 1'b1; tick();
    pwr_down = 1'b0; rd("R4 race read", A_ST);
    chk("R4 event wins", {7'b0, irq}, 8'h01);
    rd("R4 clear", A_ST);
    chk("R4 irq low", {7'b0, irq}, 8'h00);

    // R6/R8 both flip from default: only enable updates, reserved masked
    wr(A_AN, 8'hFE); rd("R8 R6 ana", A_AN);
    chk("R8 inv kept", m_ana, 8'h64);
    chk_outs("R6");
    // R7 polarity
    pa_req = 1'b1; #1 chk_outs("R7 high active");
    wr(A_AN, 8'h06); pa_req = 1'b0; #1 chk_outs("R7 low active");
    wr(A_AN, 8'h02); pa_req = 1'b1; #1 chk_outs("R7 disabled");

    // R9 soft reset with event in same cycle
    wr(A_AN, 8'h66); wr(A_EN, 8'h01);
    pwr_down = 1'b1; tick();
    pwr_down = 1'b0; wr(A_AN, 8'hFF);
    chk("R9 pulse", {7'b0, soft_rst}, 8'h01);
    chk_outs("R9 defaults");
    rd("R9 ana", A_AN);
    chk("R9 pulse end", {7'b0, soft_rst}, 8'h00);
    rd("R9 stat lost", A_ST);

    // R10 no strobe / unmapped
    bus_addr = A_AN; #1 chk("R10 no strobe", bus_rdata, 8'h00);
    rd("R10 unmapped", 8'h21);

    // random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom % 6);
      d  = 8'($urandom);
      pa_req = 1'($urandom);
      case (op)
        0: wr(A_EN, d);
        1: wr(A_AN, ($urandom % 8 == 0) ? d : (d & 8'hFE));
        2: begin
          logic [7:0] a;
          logic [1:0] s;
          s = 2'($urandom);
          a = (s == 0) ? A_EN : (s == 1) ? A_ST : (s == 2) ? A_AN : 8'($urandom);
          rd("R10 R4 rand read", a);
        end
        3: begin pwr_down = 1'($urandom); dev_ready = 1'($urandom); tick(); end
        4: wr(A_ST, d);
        default: begin
          pwr_down = 1'($urandom); bus_addr = A_ST; bus_re = 1'b1; #1;
          chk("R4 rand race", bus_rdata, exp_rd(A_ST, 1'b1));
          tick(); bus_re = 1'b0;
        end
      endcase
      chk_outs("R7 R3 rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule